// File: doc/BRIEF.md
# Dual-Select Byte-Lane Static RAM

This block is a synthesizable functional model of a 16-bit static RAM. It has two chip selects of opposite polarity, an active-low write strobe, an active-low output enable and one active-low enable for each byte lane. The block decodes three modes: idle, store and fetch. The chip is idle when it is deselected, or when neither byte lane is enabled. It stores only the enabled bytes, and it presents only the enabled bytes, and only while the output enable is low.

There are no bidirectional pads. Read data comes out on `dout` with one drive flag per byte lane. A lane whose flag is low would be high impedance on a real bus, and in this model its `dout` bits are held at zero.

The block models a store as the span of cycles in which all of its enabling conditions hold. A reference clock samples these conditions. The store is committed at the edge where the overlap is first seen to have ended, and it uses the address, data and lane enables from the last edge that saw it active.

Top module: `dual_sel_sram`

## Requirements
- R1: The block is idle when `sel_n`=1, or `sel_p`=0, or both `lane_lo_n` and `lane_hi_n` are 1. While idle, `drive_lo`=0, `drive_hi`=0 and `dout`=0.
- R2: When the block is selected with `wr_n`=0 (a store), both drive flags are 0 and `dout`=0, even when `out_en_n`=0.
- R3: When the block is selected with `wr_n`=1 and `out_en_n`=0, each enabled lane has its drive flag set and shows its stored byte. Lane 0 is `dout[7:0]`, enabled by `lane_lo_n`=0. Lane 1 is `dout[15:8]`, enabled by `lane_hi_n`=0. A lane whose enable is 1 has its flag at 0 and its bits at 0.
- R4: When the block is selected with `wr_n`=1 and `out_en_n`=1, both drive flags are 0 and `dout`=0.
- R5: A store takes place only while `sel_n`=0, `sel_p`=1, `wr_n`=0 and at least one lane enable is 0, all at once. If any one of these is missing, nothing is stored.
- R6: A store is committed at the first clock edge that finds its conditions no longer met. It uses the address, the data and the lane enables sampled at the last edge where they were met. A fetch in the cycle after that edge shows the new bytes.
- R7: The lanes are independent. `din[7:0]` is stored only if `lane_lo_n` was 0, and `din[15:8]` only if `lane_hi_n` was 0. A lane that was not enabled keeps its old byte.
- R8: An asynchronous low on `rst_n` discards any store still in progress, so that store never reaches the array. Reset does not clear the array.
- R9: Any one of the following ends a store and commits it: `sel_n` rising, `sel_p` falling, `wr_n` rising, or both lane enables going to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that samples the store overlap |
| rst_n | input | 1 | Asynchronous active-low reset of the store tracker |
| sel_n | input | 1 | Active-low chip select |
| sel_p | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low store strobe |
| out_en_n | input | 1 | Active-low output enable |
| lane_hi_n | input | 1 | Active-low enable for byte lane 1 (bits 15:8) |
| lane_lo_n | input | 1 | Active-low enable for byte lane 0 (bits 7:0) |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Store data |
| dout | output | 16 | Fetch data; zero on any lane that is not driven |
| drive_lo | output | 1 | Lane 0 is driving |
| drive_hi | output | 1 | Lane 1 is driving |

## Verification
The mode decode and the output gating are combinational, so the drive flags and `dout` follow the inputs within the same cycle. A store becomes visible one clock edge after the overlap ends: the edge that samples the overlap as gone commits it, and a fetch placed after that edge shows the new data. The bench changes inputs only just after a falling edge and compares every output at the next falling edge against a behavioural model. That model is updated on the same rising edge as the design, so each comparison falls after exactly one commit opportunity. Extra checks read words back with constant expected values after each store-ending pattern, after lane-masked stores, after address and data changes during a store, and after a reset taken in the middle of a store.

// File: rtl/dss_pkg.sv
`timescale 1ns/1ps
package dss_pkg;
   typedef enum logic [1:0] {
      DSS_IDLE  = 2'd0,
      DSS_STORE = 2'd1,
      DSS_FETCH = 2'd2
   } dss_mode_e;

   localparam int unsigned DSS_LANES = 2;
endpackage

// File: rtl/dss_mode_dec.sv
`timescale 1ns/1ps
module dss_mode_dec
   import dss_pkg::*;
#(
   parameter int unsigned LANES = DSS_LANES
) (
   input  logic             sel_n,
   input  logic             sel_p,
   input  logic             wr_n,
   input  logic [LANES-1:0] lane_n,
   output dss_mode_e        mode
);
   logic any_lane;
   logic chosen;

   assign any_lane = ~(&lane_n);
   assign chosen   = ~sel_n & sel_p & any_lane;

   always_comb begin
      if (!chosen)      mode = DSS_IDLE;
      else if (!wr_n)   mode = DSS_STORE;
      else              mode = DSS_FETCH;
   end
endmodule

// File: rtl/dss_wr_track.sv
`timescale 1ns/1ps
module dss_wr_track
   import dss_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = DSS_LANES,
   localparam int unsigned DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dss_mode_e         mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic [LANES-1:0]  lane_n,
   output logic [LANES-1:0]  cmt_en,
   output logic [ADDR_W-1:0] cmt_addr,
   output logic [DATA_W-1:0] cmt_data
);
   logic              act_now;
   logic              act_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [LANES-1:0]  lane_q;

   assign act_now = (mode == DSS_STORE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
         lane_q <= '0;
      end else begin
         act_q <= act_now;
         if (act_now) begin
            addr_q <= addr;
            data_q <= din;
            lane_q <= ~lane_n;
         end
      end
   end

   assign cmt_en   = (act_q && !act_now) ? lane_q : '0;
   assign cmt_addr = addr_q;
   assign cmt_data = data_q;
endmodule

// File: rtl/dss_lane_ram.sv
`timescale 1ns/1ps
module dss_lane_ram #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 2,
   localparam int unsigned DATA_W = LANE_W * LANES,
   localparam int unsigned DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic [LANES-1:0]  we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = store[raddr];
   end
endmodule

// File: rtl/dss_out_gate.sv
`timescale 1ns/1ps
module dss_out_gate
   import dss_pkg::*;
#(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = DSS_LANES,
   localparam int unsigned DATA_W = LANE_W * LANES
) (
   input  dss_mode_e         mode,
   input  logic              out_en_n,
   input  logic [LANES-1:0]  lane_n,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dout,
   output logic [LANES-1:0]  lane_on
);
   logic fetch_open;

   assign fetch_open = (mode == DSS_FETCH) && !out_en_n;

   for (genvar g = 0; g < LANES; g++) begin : g_gate
      assign lane_on[g] = fetch_open && !lane_n[g];
      assign dout[g*LANE_W +: LANE_W] =
         lane_on[g] ? rdata[g*LANE_W +: LANE_W] : '0;
   end
endmodule

// File: rtl/dual_sel_sram.sv
`timescale 1ns/1ps
module dual_sel_sram
   import dss_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned LANES  = DSS_LANES,
   localparam int unsigned DATA_W = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sel_p,
   input  logic              wr_n,
   input  logic              out_en_n,
   input  logic              lane_hi_n,
   input  logic              lane_lo_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              drive_lo,
   output logic              drive_hi
);
   if (ADDR_W < 1 || ADDR_W > 14) begin : g_bad_addr_w
      $error("dual_sel_sram: ADDR_W must lie in 1..14");
   end
   if (LANE_W < 1 || LANE_W > 32) begin : g_bad_lane_w
      $error("dual_sel_sram: LANE_W must lie in 1..32");
   end

   dss_mode_e         mode;
   logic [LANES-1:0]  lane_n;
   logic [LANES-1:0]  wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;
   logic [LANES-1:0]  lane_on;

   assign lane_n = {lane_hi_n, lane_lo_n};

   dss_mode_dec #(.LANES(LANES)) u_dec (
      .sel_n  (sel_n),
      .sel_p  (sel_p),
      .wr_n   (wr_n),
      .lane_n (lane_n),
      .mode   (mode)
   );

   dss_wr_track #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .addr     (addr),
      .din      (din),
      .lane_n   (lane_n),
      .cmt_en   (wr_en),
      .cmt_addr (wr_addr),
      .cmt_data (wr_data)
   );

   dss_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (addr),
      .rdata (rd_data)
   );

   dss_out_gate #(.LANE_W(LANE_W), .LANES(LANES)) u_gate (
      .mode     (mode),
      .out_en_n (out_en_n),
      .lane_n   (lane_n),
      .rdata    (rd_data),
      .dout     (dout),
      .lane_on  (lane_on)
   );

   assign drive_lo = lane_on[0];
   assign drive_hi = lane_on[1];
endmodule

// File: rtl/dss_chk.sv
`timescale 1ns/1ps
module dss_chk #(
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DATA_W = 2 * LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_n,
   input logic              sel_p,
   input logic              wr_n,
   input logic              out_en_n,
   input logic              lane_hi_n,
   input logic              lane_lo_n,
   input logic [DATA_W-1:0] dout,
   input logic              drive_lo,
   input logic              drive_hi,
   input logic              commit_lo,
   input logic              commit_hi
);
   logic picked;
   assign picked = !sel_n && sel_p && !(lane_hi_n && lane_lo_n);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !picked |-> (!drive_lo && !drive_hi && dout == '0)); // R1
   AST_STORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (picked && !wr_n) |-> (!drive_lo && !drive_hi)); // R2
   AST_FETCH_LO_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (picked && wr_n && !out_en_n && !lane_lo_n) |-> drive_lo); // R3
   AST_FETCH_HI_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (picked && wr_n && !out_en_n && !lane_hi_n) |-> drive_hi); // R3
   AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (picked && wr_n && out_en_n) |-> (!drive_lo && !drive_hi && dout == '0)); // R4
   AST_COMMIT_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_lo || commit_hi) |-> $past(picked && !wr_n)); // R6
   AST_COMMIT_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_lo || commit_hi) |-> !(picked && !wr_n)); // R9
   AST_LO_LANE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      commit_lo |-> $past(!lane_lo_n)); // R7
   AST_HI_LANE_OWN: assert property (@(posedge clk) disable iff (!rst_n)
      commit_hi |-> $past(!lane_hi_n)); // R7
endmodule

bind dual_sel_sram dss_chk #(.LANE_W(LANE_W)) u_dss_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sel_n     (sel_n),
   .sel_p     (sel_p),
   .wr_n      (wr_n),
   .out_en_n  (out_en_n),
   .lane_hi_n (lane_hi_n),
   .lane_lo_n (lane_lo_n),
   .dout      (dout),
   .drive_lo  (drive_lo),
   .drive_hi  (drive_hi),
   .commit_lo (wr_en[0]),
   .commit_hi (wr_en[1])
);

// File: tb/test_dual_sel_sram.sv
`timescale 1ns/1ps
module test_dual_sel_sram;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1, sel_p = 1'b0, wr_n = 1'b1, out_en_n = 1'b1;
   logic          lane_hi_n = 1'b1, lane_lo_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [15:0]   din = '0;
   logic [15:0]   dout;
   logic          drive_lo, drive_hi;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   dual_sel_sram #(.ADDR_W(AW), .LANE_W(8)) i_dual_sel_sram (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel_p(sel_p), .wr_n(wr_n),
      .out_en_n(out_en_n), .lane_hi_n(lane_hi_n), .lane_lo_n(lane_lo_n),
      .addr(addr), .din(din), .dout(dout), .drive_lo(drive_lo), .drive_hi(drive_hi)
   );

   // behavioural reference of the store rules
   logic [7:0]    ref_lo [DEPTH];
   logic [7:0]    ref_hi [DEPTH];
   bit            ok_lo [DEPTH];
   bit            ok_hi [DEPTH];
   bit            pend;
   int            p_addr;
   logic [15:0]   p_data;
   bit            p_lo, p_hi;
   bit            live;

   always_comb live = !sel_n && sel_p && !wr_n && (!lane_lo_n || !lane_hi_n);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else begin
         if (pend && !live) begin
            if (p_lo) begin ref_lo[p_addr] <= p_data[7:0];  ok_lo[p_addr] <= 1'b1; end
            if (p_hi) begin ref_hi[p_addr] <= p_data[15:8]; ok_hi[p_addr] <= 1'b1; end
         end
         pend <= live;
         if (live) begin
            p_addr <= int'(addr);
            p_data <= din;
            p_lo   <= !lane_lo_n;
            p_hi   <= !lane_hi_n;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic compare(input string tag);
      bit fetch, e_lo, e_hi;
      fetch = !sel_n && sel_p && !(lane_lo_n && lane_hi_n) && wr_n && !out_en_n;
      e_lo  = fetch && !lane_lo_n;
      e_hi  = fetch && !lane_hi_n;
      check({tag, " drive_lo"}, {31'd0, drive_lo}, {31'd0, e_lo});
      check({tag, " drive_hi"}, {31'd0, drive_hi}, {31'd0, e_hi});
      if (!e_lo) check({tag, " low lane zero"}, {24'd0, dout[7:0]}, 32'd0);
      else if (ok_lo[addr]) check({tag, " low lane"}, {24'd0, dout[7:0]}, {24'd0, ref_lo[addr]});
      if (!e_hi) check({tag, " high lane zero"}, {24'd0, dout[15:8]}, 32'd0);
      else if (ok_hi[addr]) check({tag, " high lane"}, {24'd0, dout[15:8]}, {24'd0, ref_hi[addr]});
   endtask

   task automatic tick(input string tag);
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic put(input logic sn, input logic sp, input logic w, input logic oe,
                      input logic hn, input logic ln, input int a, input logic [15:0] d);
      sel_n = sn; sel_p = sp; wr_n = w; out_en_n = oe;
      lane_hi_n = hn; lane_lo_n = ln; addr = AW'(a); din = d;
   endtask

   task automatic fetch_word(input int a, input logic [15:0] exp, input string tag);
      put(0, 1, 1, 0, 0, 0, a, 16'h0);
      tick(tag);
      check({tag, " word"}, {16'd0, dout}, {16'd0, exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      compare("R1 reset idle");
      tick("R1 reset idle");
      rst_n = 1'b1;
      tick("R1 after reset");

      // full-word store ended by the strobe rising
      put(0, 1, 0, 1, 0, 0, 5, 16'hA1B2); tick("R2 store");
      tick("R2 store hold");
      put(0, 1, 1, 1, 0, 0, 5, 16'h0);    tick("R9 strobe end");
      fetch_word(5, 16'hA1B2, "R6 R9 commit via strobe");

      // lane independence, ended by each select
      put(0, 1, 0, 1, 0, 0, 6, 16'h1234); tick("R5 store");
      put(1, 1, 0, 1, 0, 0, 6, 16'h1234); tick("R9 sel_n end");
      put(0, 1, 0, 0, 1, 0, 6, 16'hFFCC); tick("R2 store with oe low");
      put(1, 1, 0, 1, 1, 0, 6, 16'hFFCC); tick("R9 sel_n end");
      fetch_word(6, 16'h12CC, "R7 low lane only");
      put(0, 1, 0, 1, 0, 1, 6, 16'h56FF); tick("R7 store high");
      put(0, 0, 0, 1, 0, 1, 6, 16'h56FF); tick("R9 sel_p end");
      fetch_word(6, 16'h56CC, "R7 high lane only");

      // lane-selective fetch and output enable high
      put(0, 1, 1, 0, 1, 0, 6, 16'h0); tick("R3 low fetch");
      check("R3 low fetch", {16'd0, dout}, 32'h0000_00CC);
      put(0, 1, 1, 0, 0, 1, 6, 16'h0); tick("R3 high fetch");
      check("R3 high fetch", {16'd0, dout}, 32'h0000_5600);
      put(0, 1, 1, 1, 0, 0, 6, 16'h0); tick("R4 oe high");
      check("R4 oe high", {16'd0, dout}, 32'h0);

      // store ended by both lanes going inactive
      put(0, 1, 0, 1, 0, 0, 9, 16'hABCD); tick("R5 store");
      put(0, 1, 0, 1, 1, 1, 9, 16'hABCD); tick("R1 R9 both lanes off");
      fetch_word(9, 16'hABCD, "R9 commit via lanes");

      // partial overlaps must not store
      put(0, 1, 0, 1, 1, 1, 9, 16'hDEAD); tick("R5 no lane");
      tick("R5 no lane");
      put(1, 1, 0, 1, 0, 0, 9, 16'hDEAD); tick("R5 deselected");
      put(0, 0, 0, 1, 0, 0, 9, 16'hDEAD); tick("R5 sel_p low");
      fetch_word(9, 16'hABCD, "R5 no partial store");

      // last sampled data and address win
      put(0, 1, 0, 1, 0, 0, 7, 16'h7777); tick("R6 store");
      put(0, 1, 1, 1, 0, 0, 7, 16'h0);    tick("R6 end");
      put(0, 1, 0, 1, 0, 0, 7, 16'h1111); tick("R6 data a");
      put(0, 1, 0, 1, 0, 0, 8, 16'h2222); tick("R6 data b");
      put(0, 1, 1, 1, 0, 0, 8, 16'h0);    tick("R6 end");
      fetch_word(8, 16'h2222, "R6 last address and data");
      fetch_word(7, 16'h7777, "R6 earlier address untouched");

      // reset in mid-store discards it
      put(0, 1, 0, 1, 0, 0, 5, 16'h5A5A); tick("R8 store");
      tick("R8 store hold");
      put(1, 1, 0, 1, 0, 0, 5, 16'h5A5A);
      rst_n = 1'b0;
      tick("R8 in reset");
      rst_n = 1'b1;
      tick("R8 released");
      fetch_word(5, 16'hA1B2, "R8 store dropped");

      // sweep of mixed stores and fetches across addresses
      for (int i = 0; i < 32; i++) begin
         put(0, 1, 0, 1, (i % 3) == 1, (i % 3) == 2, 100 + i, 16'(i * 16'h0413 + 16'h0101));
         tick("R5 sweep store");
         put(0, 1, 1, 1, 0, 0, 100 + i, 16'h0);
         tick("R6 sweep end");
      end
      for (int i = 0; i < 32; i++) begin
         put(0, 1, 1, 0, (i % 4) == 3, (i % 4) == 1, 100 + i, 16'h0);
         tick("R3 sweep fetch");
      end

      put(1, 0, 1, 1, 1, 1, 0, 16'h0);
      tick("R1 final idle");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule